// File: doc/BRIEF.md
# SDRAM Start-up and Mode-Register Command Sequencer

This block drives the command pins of an SDRAM array with four chip selects. These are the active-low row strobe, column strobe, write enable and chip selects, plus the address bus. After reset it runs a fixed bring-up sequence. The sequence closes all open rows, performs two auto-refresh cycles, and then loads the mode register of each device one chip select at a time. A parameterised number of NOP cycles follows every command, so that precharge, refresh and mode-set recovery times are met.

Once bring-up is complete, a host can change the CAS latency and burst length of any bank while the system runs. The host writes the bank's parameter register and sets the operation mode to "mode-set". A dummy access to that bank is then turned into a mode-register-set on that bank's chip select alone. A second operation mode turns the next access into a refresh of only the addressed bank. In normal mode an access is reported on a pass-through strobe and issues no command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The first command after reset is a precharge of all banks. All four chip selects are low, RAS# and WE# are low, CAS# is high, and the address bus carries only bit 10 set.
- R2: T_RP NOP cycles after the precharge, the block issues two auto-refresh commands: RAS# and CAS# low, WE# high, all chip selects low, address zero. Each refresh is followed by T_RFC NOP cycles.
- R3: Four mode-register-set commands (RAS#, CAS# and WE# low) follow, each with T_MRD NOP cycles after it, and the chip selects in the order 1110, 1101, 1011, 0111. A NOP keeps the previous command's chip selects and drives RAS#, CAS# and WE# high.
- R4: The burst-mode register is at config address 1. The burst-type bit (address bit 3) of a mode value is 1 (interleaved) unless that register holds 0x09, in which case it is 0 (linear).
- R5: The mode value for bank b comes from the parameter register at config address 8+b. That register holds burst length in bits [2:0] and CAS latency in bits [6:4], and resets to 0x33. The address bus carries {zeros, CL[2:0], type, BL[2:0]}.
- R6: While reset is held and during bring-up, init_done is 0 and busy is 1. One cycle after the last bring-up NOP, init_done is 1, busy is 0 and all chip selects are high. init_done then stays 1.
- R7: With 0x03 written to the operation-mode register (config address 0), an access to bank b produces, in the next cycle, a mode-register-set on chip select b only, with b's mode value on the address bus. This is followed by T_MRD NOPs, and acc_pass stays 0.
- R8: With operation mode 0x00, an access drives acc_pass high for exactly the next cycle, and all chip selects stay high.
- R9: With operation mode 0x04, an access to bank b produces in the next cycle an auto-refresh on chip select b only, with address zero. It is followed by T_RFC NOPs and then a return to idle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| acc_req | input | 1 | Host access (dummy write) to a bank, one-cycle pulse |
| acc_bank | input | 2 | Bank targeted by the access |
| acc_pass | output | 1 | Access forwarded as an ordinary transfer |
| busy | output | 1 | Sequencer cannot accept an access |
| init_done | output | 1 | Bring-up sequence finished |
| cs_n | output | 4 | Active-low chip selects |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | SDRAM address bus |

## Verification
The assertions assume the host raises acc_req only while busy is low, and for a single cycle. They also assume config writes never change the operation mode in the middle of a command and its wait. The stimulus keeps to these rules: every access waits until the previous command and its NOPs have drained. During bring-up only the burst-mode and bank parameter registers are written, and those writes land before the mode-set step reads them. The refresh-encoding property applies only before init_done, because a forced refresh later in operation deliberately drives a single chip select.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } sdcmd_e;

    typedef enum logic [1:0] {
        ST_INIT_CMD,
        ST_INIT_WAIT,
        ST_IDLE,
        ST_RUN_WAIT
    } seq_st_e;

    localparam logic [7:0] OPM_NORMAL   = 8'h00;
    localparam logic [7:0] OPM_MRS      = 8'h03;
    localparam logic [7:0] OPM_FREF     = 8'h04;
    localparam logic [7:0] BURST_LINEAR = 8'h09;

    localparam logic [3:0] CFG_OPMODE    = 4'd0;
    localparam logic [3:0] CFG_BURST     = 4'd1;
    localparam logic [3:0] CFG_BANK_BASE = 4'd8;

    localparam logic [2:0] RST_BL = 3'b011;
    localparam logic [2:0] RST_CL = 3'd3;

endpackage

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 13
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [3:0]                       cfg_addr,
    input  logic [7:0]                       cfg_wdata,
    output logic [7:0]                       opmode,
    output logic [NUM_CS-1:0][ADDR_W-1:0]    mode_val
);

    typedef struct packed {
        logic [7:0]              opmode;
        logic [7:0]              burst;
        logic [NUM_CS-1:0][2:0]  bl;
        logic [NUM_CS-1:0][2:0]  cl;
    } cfg_s;

    cfg_s r_d, r_q;
    logic linear;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_OPMODE) r_d.opmode = cfg_wdata;
            if (cfg_addr == CFG_BURST)  r_d.burst  = cfg_wdata;
            for (int b = 0; b < NUM_CS; b++) begin
                if (cfg_addr == CFG_BANK_BASE + 4'(b)) begin
                    r_d.bl[b] = cfg_wdata[2:0];
                    r_d.cl[b] = cfg_wdata[6:4];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.opmode <= OPM_NORMAL;
            r_q.burst  <= '0;
            r_q.bl     <= {NUM_CS{RST_BL}};
            r_q.cl     <= {NUM_CS{RST_CL}};
        end else begin
            r_q <= r_d;
        end
    end

    assign opmode = r_q.opmode;
    assign linear = (r_q.burst == BURST_LINEAR);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_mode
        assign mode_val[g] = {{(ADDR_W-7){1'b0}}, r_q.cl[g], ~linear, r_q.bl[g]};
    end

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 13
) (
    input  sdcmd_e              cmd,
    input  logic [NUM_CS-1:0]   sel_n,
    input  logic [ADDR_W-1:0]   mode,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ADDR_W-1:0]   addr
);

    always_comb begin
        cs_n  = sel_n;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        case (cmd)
            CMD_PRE: begin
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = mode;
            end
            CMD_NOP: ;
            default: cs_n = '1;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 13,
    parameter int N_REF  = 2,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 3,
    parameter int T_MRD  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [3:0]                  cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic                        acc_req,
    input  logic [$clog2(NUM_CS)-1:0]   acc_bank,
    output logic                        acc_pass,
    output logic                        busy,
    output logic                        init_done,
    output logic [NUM_CS-1:0]           cs_n,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        we_n,
    output logic [ADDR_W-1:0]           addr
);

    localparam int BANK_W    = $clog2(NUM_CS);
    localparam int LAST_STEP = N_REF + NUM_CS;
    localparam int STEP_W    = $clog2(LAST_STEP + 1);
    localparam int MAX_T     = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                              : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
    localparam int CNT_W     = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_st_e              st;
        logic [STEP_W-1:0]    step;
        logic [CNT_W-1:0]     cnt;
        sdcmd_e               cmd;
        logic [NUM_CS-1:0]    sel;
        logic [ADDR_W-1:0]    mode;
        logic                 done;
        logic                 pass;
    } seq_s;

    seq_s s_d, s_q;

    logic [7:0]                     opmode;
    logic [NUM_CS-1:0][ADDR_W-1:0]  mode_val;
    logic [BANK_W-1:0]              mrs_idx;

    sdram_cfg_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .opmode    (opmode),
        .mode_val  (mode_val)
    );

    assign mrs_idx = BANK_W'(s_q.step - STEP_W'(N_REF + 1));

    always_comb begin
        s_d      = s_q;
        s_d.pass = 1'b0;
        case (s_q.st)
            ST_INIT_CMD: begin
                s_d.st  = ST_INIT_WAIT;
                s_d.sel = '0;
                if (s_q.step == '0) begin
                    s_d.cmd = CMD_PRE;
                    s_d.cnt = CNT_W'(T_RP);
                end else if (s_q.step <= STEP_W'(N_REF)) begin
                    s_d.cmd = CMD_REF;
                    s_d.cnt = CNT_W'(T_RFC);
                end else begin
                    s_d.cmd  = CMD_MRS;
                    s_d.sel  = ~(NUM_CS'(1) << mrs_idx);
                    s_d.mode = mode_val[mrs_idx];
                    s_d.cnt  = CNT_W'(T_MRD);
                end
            end
            ST_INIT_WAIT: begin
                s_d.cmd = CMD_NOP;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CNT_W'(1)) begin
                    if (s_q.step == STEP_W'(LAST_STEP)) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st   = ST_INIT_CMD;
                        s_d.step = s_q.step + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                s_d.done = 1'b1;
                s_d.cmd  = CMD_IDLE;
                s_d.sel  = '1;
                if (acc_req && s_q.done) begin
                    if (opmode == OPM_MRS) begin
                        s_d.st   = ST_RUN_WAIT;
                        s_d.cmd  = CMD_MRS;
                        s_d.sel  = ~(NUM_CS'(1) << acc_bank);
                        s_d.mode = mode_val[acc_bank];
                        s_d.cnt  = CNT_W'(T_MRD);
                    end else if (opmode == OPM_FREF) begin
                        s_d.st  = ST_RUN_WAIT;
                        s_d.cmd = CMD_REF;
                        s_d.sel = ~(NUM_CS'(1) << acc_bank);
                        s_d.cnt = CNT_W'(T_RFC);
                    end else begin
                        s_d.pass = 1'b1;
                    end
                end
            end
            default: begin
                s_d.cmd = CMD_NOP;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CNT_W'(1)) s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_INIT_CMD;
            s_q.step <= '0;
            s_q.cnt  <= '0;
            s_q.cmd  <= CMD_IDLE;
            s_q.sel  <= '1;
            s_q.mode <= '0;
            s_q.done <= 1'b0;
            s_q.pass <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_cmd_enc #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_enc (
        .cmd   (s_q.cmd),
        .sel_n (s_q.sel),
        .mode  (s_q.mode),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr)
    );

    assign acc_pass  = s_q.pass;
    assign init_done = s_q.done;
    assign busy      = !s_q.done || (s_q.st != ST_IDLE);

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              acc_pass,
    input logic              busy,
    input logic              init_done,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              a10
);

    // R1
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n && !we_n) |-> (cs_n == '0 && a10));

    // R2
    boot_ref_all_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && we_n && !init_done) |-> (cs_n == '0));

    // R3
    mrs_single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && !we_n) |-> ($countones(~cs_n) == 1));

    // R3
    cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n) |=> (ras_n && cas_n && we_n && $stable(cs_n)));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6
    busy_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> busy);

    // R8
    pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pass |-> (cs_n == '1 && !busy && $past(acc_req)));

endmodule

bind sdram_cmd_seq sdram_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_pass  (acc_pass),
    .busy      (busy),
    .init_done (init_done),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .a10       (addr[10])
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;

    localparam int TRP  = 2;
    localparam int TRFC = 3;
    localparam int TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        acc_req;
    logic [1:0]  acc_bank;
    logic        acc_pass, busy, init_done;
    logic [3:0]  cs_n;
    logic        ras_n, cas_n, we_n;
    logic [12:0] addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    sdram_cmd_seq #(.T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_bank(acc_bank),
        .acc_pass(acc_pass), .busy(busy), .init_done(init_done),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
    );

    // {cs_n[3:0], ras/cas/we, kind}: kind 0 precharge, 1 refresh, 2 mode-set
    localparam logic [8:0] INIT_TBL [7] = '{
        {4'b0000, 3'b010, 2'd0},
        {4'b0000, 3'b001, 2'd1},
        {4'b0000, 3'b001, 2'd1},
        {4'b1110, 3'b000, 2'd2},
        {4'b1101, 3'b000, 2'd2},
        {4'b1011, 3'b000, 2'd2},
        {4'b0111, 3'b000, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic logic [12:0] exp_mode(input logic [2:0] cl, input logic [2:0] bl,
                                             input logic linear);
        return {6'b0, cl, ~linear, bl};
    endfunction

    function automatic int wait_of(input logic [1:0] kind);
        return (kind == 2'd0) ? TRP : (kind == 2'd1) ? TRFC : TMRD;
    endfunction

    task automatic run_init(input logic [12:0] mexp [4]);
        for (int i = 0; i < 7; i++) begin
            logic [8:0] e;
            string tag;
            e = INIT_TBL[i];
            tag = (e[1:0] == 2'd0) ? "R1" : (e[1:0] == 2'd1) ? "R2" : "R3";
            @(negedge clk);
            chk(tag, pins(), e[8:2]);
            if (e[1:0] == 2'd0)      chk("R1 addr", addr, 13'h400);
            else if (e[1:0] == 2'd1) chk("R2 addr", addr, 13'h000);
            else                     chk("R5 mode", addr, mexp[i-3]);
            for (int w = 0; w < wait_of(e[1:0]); w++) begin
                @(negedge clk);
                chk((e[1:0] == 2'd2) ? "R3 nop" : "R2 nop", pins(), {e[8:5], 3'b111});
                chk("R6 busy in boot", {init_done, busy}, 2'b01);
            end
        end
        @(negedge clk);
        chk("R6 done", {init_done, busy}, 2'b10);
        chk("R6 idle pins", pins(), 7'h7f);
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [1:0] b);
        @(negedge clk);
        acc_req = 1'b1; acc_bank = b;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic drain(input string tag, input logic [3:0] cs, input int n);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            chk(tag, pins(), {cs, 3'b111});
        end
        @(negedge clk);
        chk(tag, {pins(), busy}, {7'h7f, 1'b0});
    endtask

    initial begin
        logic [12:0] m [4];
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_req = 1'b0; acc_bank = '0;
        repeat (3) @(negedge clk);
        chk("R6 reset pins", pins(), 7'h7f);
        chk("R6 reset flags", {init_done, busy}, 2'b01);
        rst_n = 1'b1;

        // default bring-up: interleaved, CL3 BL8 for every bank (R4, R5)
        for (int b = 0; b < 4; b++) m[b] = exp_mode(3'd3, 3'b011, 1'b0);
        run_init(m);

        // R8: normal mode forwards the access
        access(2'd1);
        chk("R8 pass", {acc_pass, pins()}, {1'b1, 7'h7f});
        @(negedge clk);
        chk("R8 pulse end", acc_pass, 1'b0);

        // R7: run-time mode-set on bank 1 with CL2 BL2
        cfg_wr(4'd9, 8'h21);
        cfg_wr(4'd0, 8'h03);
        access(2'd1);
        chk("R7 mrs pins", pins(), {4'b1101, 3'b000});
        chk("R7 mrs addr", addr, exp_mode(3'd2, 3'b001, 1'b0));
        chk("R7 no pass", {acc_pass, busy}, 2'b01);
        drain("R7 wait", 4'b1101, TMRD);

        // R7: bank 3 keeps its reset parameters
        access(2'd3);
        chk("R7 mrs bank3", {pins(), addr}, {4'b0111, 3'b000, exp_mode(3'd3, 3'b011, 1'b0)});
        drain("R7 wait3", 4'b0111, TMRD);

        // R9: forced refresh on bank 2
        cfg_wr(4'd0, 8'h04);
        access(2'd2);
        chk("R9 ref pins", pins(), {4'b1011, 3'b001});
        chk("R9 ref addr", {acc_pass, addr}, 14'd0);
        drain("R9 wait", 4'b1011, TRFC);

        // R8: back to normal mode
        cfg_wr(4'd0, 8'h00);
        access(2'd0);
        chk("R8 pass again", {acc_pass, pins()}, {1'b1, 7'h7f});

        // R4: second bring-up with linear order and bank 2 at CL2 BL4
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 4; b++) m[b] = exp_mode(3'd3, 3'b011, 1'b1);
        m[2] = exp_mode(3'd2, 3'b010, 1'b1);
        fork
            run_init(m);
            begin
                cfg_wr(4'd1, 8'h09);
                cfg_wr(4'd10, 8'h22);
            end
        join

        // R4 R7: run-time mode-set keeps linear order
        cfg_wr(4'd0, 8'h03);
        access(2'd2);
        chk("R4 R7 linear mrs", {pins(), addr}, {4'b1011, 3'b000, 13'h022});
        drain("R7 wait lin", 4'b1011, TMRD);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule